// File: doc/BRIEF.md
# Sequencer Status Pulse Encoder

This block reports what the instruction sequencer is doing over a single status wire. The kind of event is carried by how many consecutive clocks the wire stays high. A plain instruction boundary gives one clock. A boundary held back by a pending trace or interrupt gives two. The start of exception processing, or a miss in the translation cache, gives three. After a double fault the wire stays high for good. A separate refill wire pulses for one clock whenever the sequencer asks for the instruction pipeline to be reloaded.

Event strobes are one cycle wide and can arrive at any time, including while a pulse is being shown. If several strobes come in the same cycle, only the highest-ranked class is recorded. Recorded events wait in a small FIFO. They are played out in arrival order, with at least one low clock between pulses, so that an observer counting high clocks can always tell them apart. The bus-side halt input is not connected to this block and cannot affect the status wire.

Top module: `seq_status_encoder`

## Requirements
- R1: A strobe on `boundary_i` with the queue empty and the encoder idle gives a status pulse exactly 1 clock long. The pulse begins on the second rising edge after the strobe is sampled.
- R2: A strobe on `pend_exc_i` (boundary with a pending trace or interrupt) gives a status pulse exactly 2 clocks long.
- R3: A strobe on `exc_start_i` (exception processing begins) or `tc_miss_i` (translation-cache miss) gives a status pulse exactly 3 clocks long.
- R4: `dbl_fault_i` sampled high sets `status_o` high from the next clock. It stays high until reset, whatever other inputs do.
- R5: Strobes that arrive in the same cycle record one event only, chosen by rank: exception or cache miss first, then pending boundary, then plain boundary.
- R6: Queued events are shown in arrival order. Two consecutive pulses are separated by at least GAP_MIN (default 1) low clocks.
- R7: The queue holds DEPTH (default 4) waiting events. A strobe that arrives while DEPTH events are waiting is dropped.
- R8: `refill_req_i` sampled high makes `refill_o` high for exactly the next clock. This happens whatever the state of the status wire, and the refill request never changes `status_o`.
- R9: A synchronous active-high `rst` clears both outputs, the queue and the halted condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boundary_i | input | 1 | Strobe: instruction boundary, next instruction starts at once |
| pend_exc_i | input | 1 | Strobe: boundary with trace or interrupt pending |
| exc_start_i | input | 1 | Strobe: exception processing begins |
| tc_miss_i | input | 1 | Strobe: translation-cache miss, table search begins |
| dbl_fault_i | input | 1 | Double-fault halt condition |
| refill_req_i | input | 1 | Pipeline refill request |
| status_o | output | 1 | Length-coded status line |
| refill_o | output | 1 | One-clock refill strobe |

## Verification
A bad pulse counter shows up at once as a high run of the wrong length. A bad gap counter shows up as two pulses merged into one longer run. Both can be seen within four clocks of the pulse starting. A wrong queue pointer or occupancy count shows up later, when the queued events play out: a run length comes out in the wrong order, or an event appears or goes missing during the drain. The bench therefore records the lengths of the high runs over a whole burst and compares that list with the expected one. A broken halt latch shows up on the next clock, either as a status wire that drops or as one that fails to clear at reset.

// File: rtl/seq_status_pkg.sv
package seq_status_pkg;

    // Event class; the encoded value equals the pulse length in clocks.
    typedef enum logic [1:0] {
        EVC_NONE = 2'd0,
        EVC_NORM = 2'd1,
        EVC_PEND = 2'd2,
        EVC_LONG = 2'd3
    } evt_class_e;

    typedef enum logic [1:0] {
        GS_IDLE  = 2'd0,
        GS_PULSE = 2'd1,
        GS_GAP   = 2'd2,
        GS_HALT  = 2'd3
    } gen_state_e;

    typedef struct packed {
        logic       valid;
        evt_class_e cls;
    } evt_req_t;

    function automatic logic [1:0] pulse_len(input evt_class_e c);
        return logic'(c != EVC_NONE) ? 2'(c) : 2'd1;
    endfunction

endpackage

// File: rtl/seq_evt_arbiter.sv
module seq_evt_arbiter
    import seq_status_pkg::*;
(
    input  logic     boundary_i,
    input  logic     pend_exc_i,
    input  logic     exc_start_i,
    input  logic     tc_miss_i,
    output evt_req_t req_o
);
    always_comb begin
        req_o.valid = 1'b1;
        if (exc_start_i || tc_miss_i)
            req_o.cls = EVC_LONG;
        else if (pend_exc_i)
            req_o.cls = EVC_PEND;
        else if (boundary_i)
            req_o.cls = EVC_NORM;
        else begin
            req_o.cls   = EVC_NONE;
            req_o.valid = 1'b0;
        end
    end
endmodule

// File: rtl/seq_evt_fifo.sv
module seq_evt_fifo
    import seq_status_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  evt_class_e wdata,
    input  logic       pop,
    output evt_class_e rdata,
    output logic       empty,
    output logic       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    evt_class_e     mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  count;
    logic           do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= EVC_NONE;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= wdata;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (do_pop) rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == CW'(DEPTH)));

    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
        (pop && !rst) |-> !empty);
endmodule

// File: rtl/seq_pulse_gen.sv
module seq_pulse_gen
    import seq_status_pkg::*;
#(
    parameter int GAP_MIN = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_i,
    input  logic       q_empty,
    input  evt_class_e q_head,
    output logic       q_pop,
    output logic       status_o
);
    localparam int GW = $clog2(GAP_MIN + 1);

    gen_state_e    st;
    logic [1:0]    remain;
    logic [GW-1:0] gap_cnt;
    logic          can_start;
    logic [2:0]    run_cnt;

    assign can_start = (st == GS_IDLE) || (st == GS_GAP && gap_cnt == GW'(1));
    assign q_pop     = !rst && !halt_i && can_start && !q_empty;
    assign status_o  = (st == GS_PULSE) || (st == GS_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= GS_IDLE;
            remain  <= '0;
            gap_cnt <= '0;
        end else if (halt_i || st == GS_HALT) begin
            st <= GS_HALT;
        end else begin
            case (st)
                GS_PULSE: begin
                    if (remain == 2'd1) begin
                        st      <= GS_GAP;
                        gap_cnt <= GW'(GAP_MIN);
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                GS_GAP: begin
                    if (gap_cnt != GW'(1)) gap_cnt <= gap_cnt - 1'b1;
                    else if (q_empty)      st      <= GS_IDLE;
                end
                default: ;
            endcase
            if (q_pop) begin
                st     <= GS_PULSE;
                remain <= pulse_len(q_head);
            end
        end
    end

    // Independent run-length counter of the status wire for checking.
    always_ff @(posedge clk) begin
        if (rst)                 run_cnt <= '0;
        else if (!status_o)      run_cnt <= '0;
        else if (run_cnt != 3'd7) run_cnt <= run_cnt + 1'b1;
    end

    assert_run_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (st != GS_HALT) |-> (run_cnt <= 3'd3));

    assert_halt_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        halt_i |=> status_o);
endmodule

// File: rtl/seq_status_encoder.sv
module seq_status_encoder
    import seq_status_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int GAP_MIN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic boundary_i,
    input  logic pend_exc_i,
    input  logic exc_start_i,
    input  logic tc_miss_i,
    input  logic dbl_fault_i,
    input  logic refill_req_i,
    output logic status_o,
    output logic refill_o
);
    evt_req_t   req;
    evt_class_e q_head;
    logic       q_empty, q_full, q_pop;

    seq_evt_arbiter u_arb (
        .boundary_i (boundary_i),
        .pend_exc_i (pend_exc_i),
        .exc_start_i(exc_start_i),
        .tc_miss_i  (tc_miss_i),
        .req_o      (req)
    );

    seq_evt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (req.valid),
        .wdata(req.cls),
        .pop  (q_pop),
        .rdata(q_head),
        .empty(q_empty),
        .full (q_full)
    );

    seq_pulse_gen #(.GAP_MIN(GAP_MIN)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .halt_i  (dbl_fault_i),
        .q_empty (q_empty),
        .q_head  (q_head),
        .q_pop   (q_pop),
        .status_o(status_o)
    );

    always_ff @(posedge clk) begin
        if (rst) refill_o <= 1'b0;
        else     refill_o <= refill_req_i;
    end

    assert_refill_cause_R8: assert property (@(posedge clk) disable iff (rst)
        refill_o |-> $past(refill_req_i));

    assert_refill_one_clk_R8: assert property (@(posedge clk) disable iff (rst)
        (refill_o && !refill_req_i) |=> !refill_o);
endmodule

// File: tb/seq_status_encoder_test.sv
`timescale 1ns/1ps
module seq_status_encoder_test;
    logic clk = 1'b0;
    logic rst, bnd, pend, exc, tcm, dbf, rfq;
    logic status, refill;

    always #2 clk = ~clk;   // 250 MHz

    seq_status_encoder uut (
        .clk(clk), .rst(rst), .boundary_i(bnd), .pend_exc_i(pend),
        .exc_start_i(exc), .tc_miss_i(tcm), .dbl_fault_i(dbf),
        .refill_req_i(rfq), .status_o(status), .refill_o(refill)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // stimulus slots: bit3 exc, bit2 tc_miss, bit1 pend, bit0 boundary
    logic [3:0] stim [16];
    int         slen;
    int         runs [32];
    int         nruns;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v);
        exc = v[3]; tcm = v[2]; pend = v[1]; bnd = v[0];
    endtask

    // Play stim[0..slen-1] one per cycle, record high-run lengths of status.
    task automatic play(input int ncyc);
        int cur = 0;
        nruns = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (status) cur++;
            else if (cur > 0) begin
                if (nruns < 32) runs[nruns] = cur;
                nruns++;
                cur = 0;
            end
            drive((c < slen) ? stim[c] : 4'b0);
        end
        @(negedge clk);
        drive(4'b0);
    endtask

    task automatic expect_runs(input string req, input int n, input int len0,
                               input int len1, input int len2, input int len3);
        int e [4];
        e[0] = len0; e[1] = len1; e[2] = len2; e[3] = len3;
        chk({req, " run count"}, nruns, n);
        for (int i = 0; i < n && i < nruns; i++)
            chk({req, " run length"}, runs[i], (i < 4) ? e[i] : len0);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        $display("FAIL watchdog: actual timeout expected completion");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bnd = 0; pend = 0; exc = 0; tcm = 0; dbf = 0; rfq = 0;
        slen = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 status after reset", int'(status), 0);
        chk("R9 refill after reset", int'(refill), 0);
        rst = 1'b0;

        // R1 latency: strobe sampled at edge e, pulse after edge e+1
        @(negedge clk); drive(4'b0001);
        @(negedge clk); drive(4'b0000);
        chk("R1 no status one edge after strobe", int'(status), 0);
        @(negedge clk);
        chk("R1 status two edges after strobe", int'(status), 1);
        @(negedge clk);
        chk("R1 status one clock only", int'(status), 0);
        repeat (4) @(negedge clk);

        // R1, R2, R3 single events of each class
        for (int k = 0; k < 4; k++) begin
            logic [3:0] v;
            int         exp;
            v = 4'b0001 << k;
            exp = (k == 0) ? 1 : (k == 1) ? 2 : 3;
            stim[0] = v; slen = 1;
            play(12);
            expect_runs((k == 0) ? "R1" : (k == 1) ? "R2" : "R3", 1, exp, 0, 0, 0);
        end

        // R5: all same-cycle combinations of the four strobes
        for (int v = 1; v < 16; v++) begin
            int exp;
            exp = (v[3] || v[2]) ? 3 : v[1] ? 2 : 1;
            stim[0] = 4'(v); slen = 1;
            play(12);
            expect_runs("R5", 1, exp, 0, 0, 0);
        end

        // R6: ordering and gaps across consecutive events
        stim[0] = 4'b0001; stim[1] = 4'b0010; stim[2] = 4'b1000; stim[3] = 4'b0001;
        slen = 4;
        play(24);
        expect_runs("R6 order", 4, 1, 2, 3, 1);

        stim[0] = 4'b0001; stim[1] = 4'b0001; stim[2] = 4'b0001; slen = 3;
        play(16);
        expect_runs("R6 gap", 3, 1, 1, 1, 0);

        stim[0] = 4'b0100; stim[1] = 4'b0010; stim[2] = 4'b0100; stim[3] = 4'b0010;
        slen = 4;
        play(30);
        expect_runs("R6 order b", 4, 3, 2, 3, 2);

        // R7: six long events back to back; one plays at once, four queue, one dropped
        for (int i = 0; i < 6; i++) stim[i] = 4'b1000;
        slen = 6;
        play(40);
        expect_runs("R7 overflow", 5, 3, 3, 3, 3);

        // R8: refill strobe
        @(negedge clk); rfq = 1'b1;
        @(negedge clk); rfq = 1'b0;
        chk("R8 refill high next clock", int'(refill), 1);
        chk("R8 refill leaves status", int'(status), 0);
        @(negedge clk);
        chk("R8 refill one clock", int'(refill), 0);
        chk("R8 status unchanged", int'(status), 0);

        // R8 during a pulse: pulse length unaffected
        stim[0] = 4'b1000; slen = 1;
        fork
            play(12);
            begin @(negedge clk); @(negedge clk); rfq = 1'b1; @(negedge clk); rfq = 1'b0; end
        join
        expect_runs("R8 refill during pulse", 1, 3, 0, 0, 0);

        // R4: halt is continuous and ignores other inputs
        @(negedge clk); dbf = 1'b1; bnd = 1'b1;
        @(negedge clk); dbf = 1'b0; bnd = 1'b0;
        begin
            int high = 0;
            for (int i = 0; i < 30; i++) begin
                if (status) high++;
                drive(4'(i % 16));
                rfq = (i == 5);
                @(negedge clk);
                if (i == 5) chk("R8 refill while halted", int'(refill), 1);
            end
            drive(4'b0);
            chk("R4 status held high cycles", high, 30);
        end

        // R9: reset clears halt
        do_reset();
        chk("R9 status cleared after halt", int'(status), 0);
        chk("R9 refill cleared", int'(refill), 0);
        stim[0] = 4'b0010; slen = 1;
        play(12);
        expect_runs("R9 normal after reset", 1, 2, 0, 0, 0);

        // R9: reset empties a filled queue
        for (int i = 0; i < 4; i++) stim[i] = 4'b1000;
        slen = 4;
        play(3);
        do_reset();
        slen = 0;
        play(30);
        expect_runs("R9 queue flushed", 0, 0, 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule